// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a virtual address into a physical address by searching a hashed page table held in an element memory. The page-number part of the request is folded into a bucket index. The walker reads the element stored at that bucket and compares the element's page number with the requested one. If the two differ, it follows the element's forward pointer and reads again. It stops when it finds a match, when the chain ends, or when a programmable visit limit is reached. It then returns one response: hit or fault, the physical address, and the number of elements it read.

The element memory is reached through a single read port whose latency may vary from one read to the next. The walker issues one read, waits for the answer and decides its next step. At most one read is in flight at any time.

Each element holds four fields: a live bit, a page number, a frame number and a forward pointer. The head of chain `b` is the element at address `b`. Software fills the table; the walker never writes it.

Top module: `hpt_walker`

## Requirements
- R1: In the cycle after reset is released, `req_ready` is 1 and both `mem_req` and `rsp_valid` are 0.
- R2: The first element read for a request is at address H, zero-extended to the pointer width. H is the low `BKT_W` bits of (page number bits [VPN_W-1:VPN_W/2] XOR page number bits [VPN_W/2-1:0]). The page number is `req_vaddr[VA_W-1:OFF_W]`.
- R3: An element whose live bit is 1 and whose page number equals the requested one ends the walk as a hit. `rsp_paddr` is then {element frame, request offset}, with the frame in the upper `PFN_W` bits and `req_vaddr[OFF_W-1:0]` in the low bits. `rsp_depth_abort` is 0 on a hit.
- R4: When an element does not match, is live and has a nonzero forward pointer, and the limit is not yet reached, the next read is at the address given by that pointer.
- R5: A non-matching element that is not live, or whose forward pointer is all zeros, ends the walk as a fault with `rsp_hit`=0, `rsp_depth_abort`=0 and `rsp_paddr`=0.
- R6: With limit L, taken from `req_max_depth` at acceptance (a value of 0 counts as 1), a walk never reads more than L elements. A walk stopped at L by a live non-matching element with a nonzero pointer reports a fault with `rsp_depth_abort`=1 and `rsp_paddr`=0.
- R7: `rsp_visits` equals the number of element reads issued for that request.
- R8: `mem_req` is a one-cycle pulse. No new `mem_req` is raised until `mem_rsp_valid` has answered the previous one.
- R9: Each accepted request produces exactly one one-cycle `rsp_valid`. `req_ready` stays 0 from acceptance until after that response.
- R10: `req_valid` raised while `req_ready` is 0 is ignored: it causes no extra read and no extra response, and it does not change the result of the walk in progress.
- R11: A match takes priority over both stop conditions. A matching element at the limit, or one with an all-zero pointer, is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request is taken this cycle |
| req_vaddr | input | VA_W | Virtual address: page number above the offset |
| req_max_depth | input | DEPTH_W | Visit limit for this walk (0 counts as 1) |
| mem_req | output | 1 | Element read request, one cycle |
| mem_addr | output | PTR_W | Element address to read |
| mem_rsp_valid | input | 1 | Element read data valid |
| mem_rsp_live | input | 1 | Element holds a mapping |
| mem_rsp_vpn | input | VPN_W | Element page number |
| mem_rsp_pfn | input | PFN_W | Element frame number |
| mem_rsp_next | input | PTR_W | Element forward pointer, 0 = end of chain |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_hit | output | 1 | Translation found |
| rsp_depth_abort | output | 1 | Walk stopped by the visit limit |
| rsp_paddr | output | PA_W | Physical address on a hit, else 0 |
| rsp_visits | output | DEPTH_W | Elements read for this walk |

## Verification
The bench builds the walker with a 10-bit page number, a 4-bit offset, an 8-bit frame, a 6-bit pointer (64 elements), 8 buckets and a 3-bit limit. With only 8 buckets, random lookups collide often, so chains of several elements are common. Random forward pointers create cycles in the table, and the small limit width lets those cycles reach the abort path quickly. Every read address is compared with the path the bench computes for the request. Read latency varies from 1 to 4 cycles, which exercises the wait on each element.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    // Default geometry of the walker
    localparam int unsigned DEF_VPN_W   = 16;
    localparam int unsigned DEF_OFF_W   = 12;
    localparam int unsigned DEF_PFN_W   = 16;
    localparam int unsigned DEF_PTR_W   = 8;
    localparam int unsigned DEF_BKT_W   = 6;
    localparam int unsigned DEF_DEPTH_W = 4;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ISSUE = 2'd1,
        WS_WAIT  = 2'd2,
        WS_RESP  = 2'd3
    } walk_state_e;

    // Outcome of inspecting one element
    typedef struct packed {
        logic done;
        logic hit;
        logic depth_abort;
    } walk_verdict_t;

endpackage

// File: rtl/hpt_hash_fold.sv
module hpt_hash_fold #(
    parameter int unsigned VPN_W = hpt_pkg::DEF_VPN_W,
    parameter int unsigned BKT_W = hpt_pkg::DEF_BKT_W
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [BKT_W-1:0] bucket
);
    localparam int unsigned LO_W = VPN_W / 2;
    localparam int unsigned HI_W = VPN_W - LO_W;

    logic [HI_W-1:0] folded;

    // Upper half XOR lower half, then keep the bucket bits
    always_comb begin
        folded = vpn[VPN_W-1:LO_W] ^ HI_W'(vpn[LO_W-1:0]);
        bucket = folded[BKT_W-1:0];
    end
endmodule

// File: rtl/hpt_elem_match.sv
module hpt_elem_match
    import hpt_pkg::*;
#(
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PTR_W   = DEF_PTR_W,
    parameter int unsigned DEPTH_W = DEF_DEPTH_W
) (
    input  logic               elem_live,
    input  logic [VPN_W-1:0]   elem_vpn,
    input  logic [PTR_W-1:0]   elem_next,
    input  logic [VPN_W-1:0]   want_vpn,
    input  logic [DEPTH_W-1:0] visits,
    input  logic [DEPTH_W-1:0] limit,
    output walk_verdict_t      verdict
);
    logic is_match;
    logic chain_end;
    logic at_limit;

    always_comb begin
        is_match  = elem_live && (elem_vpn == want_vpn);
        chain_end = !elem_live || (elem_next == '0);
        at_limit  = visits >= limit;
        // a match wins over both stop conditions
        verdict.hit         = is_match;
        verdict.depth_abort = !is_match && !chain_end && at_limit;
        verdict.done        = is_match || chain_end || at_limit;
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned OFF_W   = DEF_OFF_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    parameter int unsigned PTR_W   = DEF_PTR_W,
    parameter int unsigned BKT_W   = DEF_BKT_W,
    parameter int unsigned DEPTH_W = DEF_DEPTH_W,
    localparam int unsigned VA_W   = VPN_W + OFF_W,
    localparam int unsigned PA_W   = PFN_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [DEPTH_W-1:0] req_max_depth,
    output logic               mem_req,
    output logic [PTR_W-1:0]   mem_addr,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_live,
    input  logic [VPN_W-1:0]   mem_rsp_vpn,
    input  logic [PFN_W-1:0]   mem_rsp_pfn,
    input  logic [PTR_W-1:0]   mem_rsp_next,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_depth_abort,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [DEPTH_W-1:0] rsp_visits
);
    walk_state_e        state_q;
    logic [VPN_W-1:0]   vpn_q;
    logic [OFF_W-1:0]   off_q;
    logic [DEPTH_W-1:0] lim_q;
    logic [DEPTH_W-1:0] visits_q;
    logic [DEPTH_W-1:0] visits_nx;
    logic [PTR_W-1:0]   addr_q;
    logic               hit_q;
    logic               abort_q;
    logic [PA_W-1:0]    paddr_q;
    logic [BKT_W-1:0]   bucket;
    logic [DEPTH_W-1:0] eff_limit;
    walk_verdict_t      verdict;

    hpt_hash_fold #(
        .VPN_W (VPN_W),
        .BKT_W (BKT_W)
    ) u_hash (
        .vpn    (req_vaddr[VA_W-1:OFF_W]),
        .bucket (bucket)
    );

    hpt_elem_match #(
        .VPN_W   (VPN_W),
        .PTR_W   (PTR_W),
        .DEPTH_W (DEPTH_W)
    ) u_match (
        .elem_live (mem_rsp_live),
        .elem_vpn  (mem_rsp_vpn),
        .elem_next (mem_rsp_next),
        .want_vpn  (vpn_q),
        .visits    (visits_nx),
        .limit     (lim_q),
        .verdict   (verdict)
    );

    always_comb begin
        visits_nx = visits_q + 1'b1;
        eff_limit = (req_max_depth == '0) ? DEPTH_W'(1) : req_max_depth;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WS_IDLE;
            vpn_q    <= '0;
            off_q    <= '0;
            lim_q    <= '0;
            visits_q <= '0;
            addr_q   <= '0;
            hit_q    <= 1'b0;
            abort_q  <= 1'b0;
            paddr_q  <= '0;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    if (req_valid) begin
                        vpn_q    <= req_vaddr[VA_W-1:OFF_W];
                        off_q    <= req_vaddr[OFF_W-1:0];
                        lim_q    <= eff_limit;
                        visits_q <= '0;
                        addr_q   <= PTR_W'(bucket);
                        state_q  <= WS_ISSUE;
                    end
                end
                WS_ISSUE: state_q <= WS_WAIT;
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        visits_q <= visits_nx;
                        if (verdict.done) begin
                            hit_q   <= verdict.hit;
                            abort_q <= verdict.depth_abort;
                            paddr_q <= verdict.hit ? {mem_rsp_pfn, off_q} : '0;
                            state_q <= WS_RESP;
                        end else begin
                            addr_q  <= mem_rsp_next;
                            state_q <= WS_ISSUE;
                        end
                    end
                end
                WS_RESP: state_q <= WS_IDLE;
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready       = (state_q == WS_IDLE);
        mem_req         = (state_q == WS_ISSUE);
        mem_addr        = addr_q;
        rsp_valid       = (state_q == WS_RESP);
        rsp_hit         = hit_q;
        rsp_depth_abort = abort_q;
        rsp_paddr       = paddr_q;
        rsp_visits      = visits_q;
    end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
    parameter int unsigned VPN_W   = hpt_pkg::DEF_VPN_W,
    parameter int unsigned OFF_W   = hpt_pkg::DEF_OFF_W,
    parameter int unsigned PFN_W   = hpt_pkg::DEF_PFN_W,
    parameter int unsigned PTR_W   = hpt_pkg::DEF_PTR_W,
    parameter int unsigned BKT_W   = hpt_pkg::DEF_BKT_W,
    parameter int unsigned DEPTH_W = hpt_pkg::DEF_DEPTH_W,
    localparam int unsigned VA_W   = VPN_W + OFF_W,
    localparam int unsigned PA_W   = PFN_W + OFF_W
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VA_W-1:0]    req_vaddr,
    input logic [DEPTH_W-1:0] req_max_depth,
    input logic               mem_req,
    input logic [PTR_W-1:0]   mem_addr,
    input logic               mem_rsp_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_depth_abort,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic [DEPTH_W-1:0] rsp_visits
);
    localparam int unsigned LO_W = VPN_W / 2;
    localparam int unsigned HI_W = VPN_W - LO_W;

    function automatic logic [PTR_W-1:0] start_addr(input logic [VA_W-1:0] va);
        logic [HI_W-1:0] f;
        f = va[VA_W-1:OFF_W+LO_W] ^ HI_W'(va[OFF_W+LO_W-1:OFF_W]);
        return PTR_W'(f[BKT_W-1:0]);
    endfunction

    logic               in_flight;
    logic [DEPTH_W-1:0] lim_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight <= 1'b0;
            lim_cap   <= '0;
        end else begin
            if (mem_req)            in_flight <= 1'b1;
            else if (mem_rsp_valid) in_flight <= 1'b0;
            if (req_valid && req_ready)
                lim_cap <= (req_max_depth == '0) ? DEPTH_W'(1) : req_max_depth;
        end
    end

    // R1: idle outputs after reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_req && !rsp_valid));

    // R2: first read goes to the hashed bucket
    a_r2_first_read_bucket: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_req && mem_addr == start_addr($past(req_vaddr))));

    // R3: a hit is never an abort
    a_r3_hit_not_abort: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> !rsp_depth_abort);

    // R5: a fault carries a zero address
    a_r5_fault_paddr_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));

    // R6: visits within the captured limit
    a_r6_visits_bounded: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_visits != '0 && rsp_visits <= lim_cap));

    // R6: an abort happens exactly at the limit
    a_r6_abort_at_limit: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_depth_abort) |-> (rsp_visits == lim_cap));

    // R8: read request is a single-cycle pulse
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R8: no second read while one is outstanding
    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !in_flight);

    // R9: response is a pulse and excludes readiness
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r9_busy_on_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);
endmodule

bind hpt_walker hpt_walker_chk #(
    .VPN_W   (VPN_W),
    .OFF_W   (OFF_W),
    .PFN_W   (PFN_W),
    .PTR_W   (PTR_W),
    .BKT_W   (BKT_W),
    .DEPTH_W (DEPTH_W)
) chk_i (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_vaddr       (req_vaddr),
    .req_max_depth   (req_max_depth),
    .mem_req         (mem_req),
    .mem_addr        (mem_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_depth_abort (rsp_depth_abort),
    .rsp_paddr       (rsp_paddr),
    .rsp_visits      (rsp_visits)
);

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P_VPN   = 10;
    localparam int P_OFF   = 4;
    localparam int P_PFN   = 8;
    localparam int P_PTR   = 6;
    localparam int P_BKT   = 3;
    localparam int P_DEPTH = 3;
    localparam int P_VA    = P_VPN + P_OFF;
    localparam int P_PA    = P_PFN + P_OFF;
    localparam int NE      = 1 << P_PTR;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [P_VA-1:0]    req_vaddr = '0;
    logic [P_DEPTH-1:0] req_max_depth = '0;
    logic               mem_req;
    logic [P_PTR-1:0]   mem_addr;
    logic               mem_rsp_valid = 1'b0;
    logic               mem_rsp_live = 1'b0;
    logic [P_VPN-1:0]   mem_rsp_vpn = '0;
    logic [P_PFN-1:0]   mem_rsp_pfn = '0;
    logic [P_PTR-1:0]   mem_rsp_next = '0;
    logic               rsp_valid;
    logic               rsp_hit;
    logic               rsp_depth_abort;
    logic [P_PA-1:0]    rsp_paddr;
    logic [P_DEPTH-1:0] rsp_visits;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpt_walker #(
        .VPN_W(P_VPN), .OFF_W(P_OFF), .PFN_W(P_PFN),
        .PTR_W(P_PTR), .BKT_W(P_BKT), .DEPTH_W(P_DEPTH)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_max_depth(req_max_depth),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_live(mem_rsp_live), .mem_rsp_vpn(mem_rsp_vpn),
        .mem_rsp_pfn(mem_rsp_pfn), .mem_rsp_next(mem_rsp_next),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_depth_abort(rsp_depth_abort),
        .rsp_paddr(rsp_paddr), .rsp_visits(rsp_visits)
    );

    // bench copy of the element memory
    bit               t_live [NE];
    logic [P_VPN-1:0] t_vpn  [NE];
    logic [P_PFN-1:0] t_pfn  [NE];
    logic [P_PTR-1:0] t_next [NE];

    int n_checks = 0;
    int n_err    = 0;
    int rd_cnt   = 0;

    // expected walk
    int  exp_path [16];
    int  exp_len;
    bit  exp_hit;
    bit  exp_abort;
    logic [P_PFN-1:0] exp_pfn;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int bucket_of(input logic [P_VPN-1:0] v);
        logic [4:0] f;
        f = v[9:5] ^ v[4:0];
        return int'(f[2:0]);
    endfunction

    task automatic ref_walk(input logic [P_VPN-1:0] v, input int lim);
        int a;
        int eff;
        a = bucket_of(v);
        eff = (lim == 0) ? 1 : lim;
        exp_len = 0; exp_hit = 0; exp_abort = 0; exp_pfn = '0;
        for (int k = 0; k < 16; k++) begin
            exp_path[exp_len] = a;
            exp_len++;
            if (t_live[a] && t_vpn[a] == v) begin
                exp_hit = 1; exp_pfn = t_pfn[a]; break;
            end else if (!t_live[a] || t_next[a] == '0) begin
                break;
            end else if (exp_len >= eff) begin
                exp_abort = 1; break;
            end
            a = int'(t_next[a]);
        end
    endtask

    // element memory model with 1..4 cycle latency; checks each read address (R2, R4)
    initial begin
        forever begin
            int lat;
            int a;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (!rst && mem_req) begin
                a = int'(mem_addr);
                if (rd_cnt < exp_len)
                    chk(a == exp_path[rd_cnt], (rd_cnt == 0) ? "R2" : "R4",
                        "read address", a, exp_path[rd_cnt]);
                else
                    chk(1'b0, "R6", "read beyond expected walk", rd_cnt, exp_len);
                rd_cnt++;
                lat = 1 + int'($urandom % 4);
                repeat (lat) @(negedge clk);
                mem_rsp_live  = t_live[a];
                mem_rsp_vpn   = t_vpn[a];
                mem_rsp_pfn   = t_pfn[a];
                mem_rsp_next  = t_next[a];
                mem_rsp_valid = 1'b1;
            end
        end
    end

    task automatic do_walk(input logic [P_VA-1:0] va, input int lim,
                           input string tag, input bit inject);
        int wait_cyc;
        ref_walk(va[P_VA-1:P_OFF], lim);
        rd_cnt = 0;
        @(negedge clk);
        req_vaddr     = va;
        req_max_depth = P_DEPTH'(lim);
        req_valid     = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            // R10: request while busy must be ignored
            @(negedge clk);
            req_vaddr     = va ^ {10'h021, 4'h5};
            req_max_depth = 3'd1;
            req_valid     = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        wait_cyc = 0;
        while (!rsp_valid && wait_cyc < 200) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk(rsp_valid, "R9", {tag, " response arrives"}, rsp_valid, 1);
        chk(rsp_hit == exp_hit, exp_hit ? "R3" : "R5", {tag, " hit"}, rsp_hit, exp_hit);
        chk(rsp_depth_abort == exp_abort, "R6", {tag, " depth abort"},
            rsp_depth_abort, exp_abort);
        chk(rsp_paddr == (exp_hit ? {exp_pfn, va[P_OFF-1:0]} : '0), "R3",
            {tag, " paddr"}, rsp_paddr, exp_hit ? {exp_pfn, va[P_OFF-1:0]} : '0);
        chk(int'(rsp_visits) == exp_len, "R7", {tag, " visits"}, rsp_visits, exp_len);
        chk(rd_cnt == exp_len, "R7", {tag, " read count"}, rd_cnt, exp_len);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R9", {tag, " single response"}, rsp_valid, 0);
        if (inject) begin
            repeat (20) @(negedge clk);
            chk(rd_cnt == exp_len && !rsp_valid, "R10", "no extra activity after busy request",
                rd_cnt, exp_len);
        end
    endtask

    task automatic clear_table();
        for (int i = 0; i < NE; i++) begin
            t_live[i] = 0; t_vpn[i] = '0; t_pfn[i] = '0; t_next[i] = '0;
        end
    endtask

    task automatic set_elem(input int a, input bit lv, input logic [P_VPN-1:0] v,
                            input logic [P_PFN-1:0] f, input logic [P_PTR-1:0] n);
        t_live[a] = lv; t_vpn[a] = v; t_pfn[a] = f; t_next[a] = n;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got hung expected finished run");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [P_VPN-1:0] v1;
        logic [P_VPN-1:0] v2;
        int b;
        void'($urandom(32'd2024));
        clear_table();
        exp_len = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

        v1 = 10'h2B6;
        v2 = v1 ^ 10'h021;          // same bucket as v1
        b  = bucket_of(v1);

        // R5: empty bucket head
        do_walk({v1, 4'h3}, 7, "R5 empty head", 0);
        // R3: hit at head
        set_elem(b, 1, v1, 8'h5A, '0);
        do_walk({v1, 4'hC}, 7, "R3 head hit", 0);
        // R4: hit at third element
        set_elem(b, 1, v1 ^ 10'h042, 8'h11, 6'd20);
        set_elem(20, 1, v1 ^ 10'h084, 8'h22, 6'd21);
        set_elem(21, 1, v1, 8'h33, '0);
        do_walk({v1, 4'h9}, 7, "R4 chain hit", 0);
        // R5: end of chain fault
        do_walk({v2, 4'h1}, 7, "R5 chain end", 0);
        // R10: busy requests ignored
        do_walk({v1, 4'h7}, 7, "R10 busy", 1);
        // R6: cycle in chain aborts at limit
        set_elem(21, 1, v1, 8'h33, 6'd20);
        do_walk({v2, 4'h2}, 5, "R6 loop abort", 0);
        // R6: limit 0 counts as 1
        do_walk({v2, 4'h2}, 0, "R6 zero limit", 0);
        // R11: match at the limit is a hit
        do_walk({v1, 4'hF}, 3, "R11 match at limit", 0);
        // R5: dead element mid-chain ends walk
        set_elem(20, 0, v1 ^ 10'h084, 8'h22, 6'd21);
        do_walk({v1, 4'h4}, 7, "R5 dead element", 0);

        // random tables
        for (int t = 0; t < 10; t++) begin
            for (int i = 0; i < NE; i++)
                set_elem(i, ($urandom % 8) != 0, P_VPN'($urandom), P_PFN'($urandom),
                         (($urandom % 3) == 0) ? '0 : P_PTR'($urandom));
            for (int q = 0; q < 30; q++) begin
                logic [P_VPN-1:0] v;
                int a;
                int steps;
                v = P_VPN'($urandom);
                if (($urandom % 2) == 0) begin
                    a = bucket_of(v);
                    steps = int'($urandom % 4);
                    for (int s = 0; s < steps; s++)
                        if (t_live[a] && t_next[a] != '0) a = int'(t_next[a]);
                    t_live[a] = 1;
                    t_vpn[a]  = v;
                end
                do_walk({v, P_OFF'($urandom)}, int'($urandom % 8), "R3/R6 random", 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule